// File: doc/BRIEF.md
# Three-way in-order instruction dispatcher

This block sits between an in-order instruction buffer and three issue queues, one each for floating-point, vector and general-purpose work. Fetch appends decoded instructions to the top of a twelve-entry buffer. Each cycle the dispatcher looks only at the three oldest entries and sends out the longest run of them, starting from the oldest, that can all be accepted. An entry is blocked when its issue queue has used up its per-cycle admission allowance, when that queue reports no free room, or when no completion-queue credit is left for it.

Dispatched instructions go out on a three-lane bus. Each lane carries a valid bit, a class tag and the instruction payload, and each issue queue takes the lanes whose tag names it. After dispatch the remaining entries collapse towards the bottom of the buffer, so the oldest live instruction is always in slot 0. Instructions fetched in the same cycle land directly above the survivors. A flush empties the buffer in one cycle and blocks dispatch for that cycle.

Top module: `iq_dispatch`

## Requirements
- R1: The buffer holds at most 12 instructions. `fe_ready` is high exactly when at least 3 entries are free. While it is low, the lanes offered on the fetch port are dropped.
- R2: Only buffer slots 0, 1 and 2 are eligible in a cycle. Lane k of the dispatch bus carries slot k, and a fourth waiting instruction never goes out in the same cycle.
- R3: Dispatch is a prefix in program order. If a slot is blocked, no younger slot dispatches in that cycle, so `dsp_valid` is always 000, 001, 011 or 111.
- R4: Class tags are 00 = no issue queue, 01 = general, 10 = floating-point, 11 = vector. Per cycle at most 1 floating-point, 2 vector and 3 general instructions dispatch. Each of these counts is further capped by that queue's `*_slots` input.
- R5: The number of instructions dispatched in a cycle never exceeds `cq_free`. This includes tag-00 instructions.
- R6: A tag-00 instruction needs a completion credit and a dispatch lane, but no issue-queue room.
- R7: Entries that did not dispatch shift down in order. Fetch lanes accepted in the same cycle are appended directly above them, lane 0 first.
- R8: While `flush` is high, `dsp_valid` is 000. On the next cycle the buffer is empty, and fetch lanes offered during the flush are discarded.
- R9: After reset the buffer is empty, `dsp_valid` is 000 and `fe_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard every buffered instruction |
| fe_cnt | input | 2 | Number of fetch lanes offered, taken from lane 0 upward |
| fe_cls | input | 6 | Class tag for each fetch lane, 2 bits per lane |
| fe_data | input | 96 | Payload for each fetch lane, 32 bits per lane |
| fe_ready | output | 1 | Buffer can take a full fetch group this cycle |
| fp_slots | input | 2 | Free room reported by the floating-point issue queue |
| vec_slots | input | 2 | Free room reported by the vector issue queue |
| gen_slots | input | 2 | Free room reported by the general issue queue |
| cq_free | input | 5 | Free completion-queue entries |
| dsp_valid | output | 3 | Per-lane dispatch valid |
| dsp_cls | output | 6 | Per-lane class tag |
| dsp_data | output | 96 | Per-lane instruction payload |

## Verification
The assertions assume that `fe_cnt` never exceeds the fetch width of three and that the slot and credit inputs are valid counts (0 to 3 for the slot inputs, 0 to 16 for `cq_free`). They do not assume that fetch respects `fe_ready`, because the block is required to drop lanes that are offered while it is low. The stimulus drives every input at the falling edge, always with legal counts. It deliberately offers a full fetch group into a full buffer and during a flush, so that the dropping paths are exercised.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE = 2'd0,
    CLS_GEN  = 2'd1,
    CLS_FP   = 2'd2,
    CLS_VEC  = 2'd3
  } cls_e;

  // admission allowance of one issue queue in one cycle
  function automatic int cap_of(input int lim, input int room);
    return (room < lim) ? room : lim;
  endfunction

  // buffer can absorb a whole fetch group
  function automatic logic space_ok(input int occ, input int depth, input int fetch_w);
    return (depth - occ) >= fetch_w;
  endfunction

  // occupancy after dispatch and append
  function automatic int next_fill(input int occ, input int gone, input int added);
    return occ - gone + added;
  endfunction

endpackage

// File: rtl/dsp_pick.sv
`timescale 1ns/1ps
module dsp_pick
  import dsp_pkg::*;
#(
  parameter int WIN      = 3,
  parameter int MAX_DISP = 3,
  parameter int FP_LIM   = 1,
  parameter int VEC_LIM  = 2,
  parameter int GEN_LIM  = 3,
  parameter int CQ_W     = 5,
  parameter int SLOT_W   = 2,
  localparam int NGO_W   = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0]    slot_vld,
  input  cls_e              slot_cls [WIN],
  input  logic [SLOT_W-1:0] fp_slots,
  input  logic [SLOT_W-1:0] vec_slots,
  input  logic [SLOT_W-1:0] gen_slots,
  input  logic [CQ_W-1:0]   cq_free,
  input  logic              hold,
  output logic [WIN-1:0]    go,
  output logic [NGO_W-1:0]  n_go
);

  always_comb begin
    int   fp_c, vec_c, gen_c, tot;
    int   fp_cap, vec_cap, gen_cap;
    logic run, cq_ok, iq_ok;
    fp_cap  = cap_of(FP_LIM,  int'(fp_slots));
    vec_cap = cap_of(VEC_LIM, int'(vec_slots));
    gen_cap = cap_of(GEN_LIM, int'(gen_slots));
    fp_c  = 0;
    vec_c = 0;
    gen_c = 0;
    tot   = 0;
    run   = !hold;
    go    = '0;
    for (int i = 0; i < WIN; i++) begin
      cq_ok = tot < int'(cq_free);
      case (slot_cls[i])
        CLS_FP:  iq_ok = fp_c  < fp_cap;
        CLS_VEC: iq_ok = vec_c < vec_cap;
        CLS_GEN: iq_ok = gen_c < gen_cap;
        default: iq_ok = 1'b1;
      endcase
      if (run && slot_vld[i] && (tot < MAX_DISP) && cq_ok && iq_ok) begin
        go[i] = 1'b1;
        tot   = tot + 1;
        case (slot_cls[i])
          CLS_FP:  fp_c  = fp_c + 1;
          CLS_VEC: vec_c = vec_c + 1;
          CLS_GEN: gen_c = gen_c + 1;
          default: ;
        endcase
      end else begin
        run = 1'b0;
      end
    end
    n_go = tot[NGO_W-1:0];
  end

endmodule

// File: rtl/dsp_iq.sv
`timescale 1ns/1ps
module dsp_iq
  import dsp_pkg::*;
#(
  parameter int DEPTH    = 12,
  parameter int FETCH_W  = 3,
  parameter int DATA_W   = 32,
  parameter int WIN      = 3,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int FC_W    = $clog2(FETCH_W + 1),
  localparam int NGO_W   = $clog2(WIN + 1),
  localparam int IDX_W   = $clog2(DEPTH + WIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [FC_W-1:0]           fe_cnt,
  input  logic [FETCH_W*CLS_W-1:0]  fe_cls,
  input  logic [FETCH_W*DATA_W-1:0] fe_data,
  input  logic [NGO_W-1:0]          n_go,
  output logic                      room_ok,
  output logic [CNT_W-1:0]          occ,
  output logic [WIN-1:0]            slot_vld,
  output cls_e                      slot_cls [WIN],
  output logic [DATA_W-1:0]         slot_data [WIN]
);

  logic [DATA_W-1:0] mem_d [DEPTH];
  cls_e              mem_c [DEPTH];
  logic [DATA_W-1:0] nxt_d [DEPTH];
  cls_e              nxt_c [DEPTH];
  logic [CNT_W-1:0]  occ_q;
  logic [CNT_W-1:0]  occ_n;

  assign room_ok = space_ok(int'(occ_q), DEPTH, FETCH_W);
  assign occ     = occ_q;

  // collapse survivors downward, append accepted fetch lanes above them
  always_comb begin
    int keep, take, src, k, fill;
    keep = int'(occ_q) - int'(n_go);
    take = room_ok ? int'(fe_cnt) : 0;
    for (int j = 0; j < DEPTH; j++) begin
      src      = j + int'(n_go);
      k        = j - keep;
      nxt_d[j] = mem_d[j];
      nxt_c[j] = mem_c[j];
      if (src < int'(occ_q)) begin
        nxt_d[j] = mem_d[src[IDX_W-1:0]];
        nxt_c[j] = mem_c[src[IDX_W-1:0]];
      end else if (k >= 0 && k < take) begin
        nxt_d[j] = fe_data[k*DATA_W +: DATA_W];
        nxt_c[j] = cls_e'(fe_cls[k*CLS_W +: CLS_W]);
      end
    end
    fill  = next_fill(int'(occ_q), int'(n_go), take);
    occ_n = flush ? '0 : fill[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_n;
  end

  always_ff @(posedge clk) begin
    mem_d <= nxt_d;
    mem_c <= nxt_c;
  end

  for (genvar w = 0; w < WIN; w++) begin : g_slot
    assign slot_vld[w]  = occ_q > CNT_W'(w);
    assign slot_cls[w]  = mem_c[w];
    assign slot_data[w] = mem_d[w];
  end

endmodule

// File: rtl/iq_dispatch.sv
`timescale 1ns/1ps
module iq_dispatch
  import dsp_pkg::*;
#(
  parameter int IQ_DEPTH = 12,
  parameter int WIN      = 3,
  parameter int MAX_DISP = 3,
  parameter int FETCH_W  = 3,
  parameter int DATA_W   = 32,
  parameter int FP_LIM   = 1,
  parameter int VEC_LIM  = 2,
  parameter int GEN_LIM  = 3,
  parameter int CQ_DEPTH = 16,
  localparam int CQ_W    = $clog2(CQ_DEPTH + 1),
  localparam int SLOT_W  = $clog2(MAX_DISP + 1),
  localparam int FC_W    = $clog2(FETCH_W + 1),
  localparam int CNT_W   = $clog2(IQ_DEPTH + 1),
  localparam int NGO_W   = $clog2(WIN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [FC_W-1:0]           fe_cnt,
  input  logic [FETCH_W*CLS_W-1:0]  fe_cls,
  input  logic [FETCH_W*DATA_W-1:0] fe_data,
  output logic                      fe_ready,
  input  logic [SLOT_W-1:0]         fp_slots,
  input  logic [SLOT_W-1:0]         vec_slots,
  input  logic [SLOT_W-1:0]         gen_slots,
  input  logic [CQ_W-1:0]           cq_free,
  output logic [WIN-1:0]            dsp_valid,
  output logic [WIN*CLS_W-1:0]      dsp_cls,
  output logic [WIN*DATA_W-1:0]     dsp_data
);

  // named internal events, observed by the bound checker
  logic [CNT_W-1:0]  occ;
  logic [NGO_W-1:0]  disp_n;
  logic              room_ok;
  logic [WIN-1:0]    slot_vld;
  cls_e              slot_cls  [WIN];
  logic [DATA_W-1:0] slot_data [WIN];
  logic [WIN-1:0]    go;

  dsp_iq #(
    .DEPTH   (IQ_DEPTH),
    .FETCH_W (FETCH_W),
    .DATA_W  (DATA_W),
    .WIN     (WIN)
  ) u_iq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .fe_cnt    (fe_cnt),
    .fe_cls    (fe_cls),
    .fe_data   (fe_data),
    .n_go      (disp_n),
    .room_ok   (room_ok),
    .occ       (occ),
    .slot_vld  (slot_vld),
    .slot_cls  (slot_cls),
    .slot_data (slot_data)
  );

  dsp_pick #(
    .WIN      (WIN),
    .MAX_DISP (MAX_DISP),
    .FP_LIM   (FP_LIM),
    .VEC_LIM  (VEC_LIM),
    .GEN_LIM  (GEN_LIM),
    .CQ_W     (CQ_W),
    .SLOT_W   (SLOT_W)
  ) u_pick (
    .slot_vld  (slot_vld),
    .slot_cls  (slot_cls),
    .fp_slots  (fp_slots),
    .vec_slots (vec_slots),
    .gen_slots (gen_slots),
    .cq_free   (cq_free),
    .hold      (flush),
    .go        (go),
    .n_go      (disp_n)
  );

  assign fe_ready = room_ok;

  for (genvar w = 0; w < WIN; w++) begin : g_lane
    assign dsp_valid[w]                  = go[w];
    assign dsp_cls[w*CLS_W +: CLS_W]     = slot_cls[w];
    assign dsp_data[w*DATA_W +: DATA_W]  = slot_data[w];
  end

endmodule

// File: rtl/dsp_chk.sv
`timescale 1ns/1ps
module dsp_chk #(
  parameter int IQ_DEPTH = 12,
  parameter int WIN      = 3,
  parameter int FETCH_W  = 3,
  parameter int FP_LIM   = 1,
  parameter int VEC_LIM  = 2,
  parameter int GEN_LIM  = 3,
  parameter int CQ_W     = 5,
  parameter int SLOT_W   = 2,
  parameter int FC_W     = 2,
  parameter int CNT_W    = 4,
  parameter int NGO_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [FC_W-1:0]   fe_cnt,
  input logic              fe_ready,
  input logic [SLOT_W-1:0] fp_slots,
  input logic [SLOT_W-1:0] vec_slots,
  input logic [SLOT_W-1:0] gen_slots,
  input logic [CQ_W-1:0]   cq_free,
  input logic [WIN-1:0]    dsp_valid,
  input logic [WIN*2-1:0]  dsp_cls,
  input logic [CNT_W-1:0]  occ,
  input logic [NGO_W-1:0]  disp_n
);

  int fp_n, vec_n, gen_n;
  always_comb begin
    fp_n = 0; vec_n = 0; gen_n = 0;
    for (int i = 0; i < WIN; i++) begin
      if (dsp_valid[i]) begin
        case (dsp_cls[i*2 +: 2])
          2'd1: gen_n = gen_n + 1;
          2'd2: fp_n  = fp_n + 1;
          2'd3: vec_n = vec_n + 1;
          default: ;
        endcase
      end
    end
  end

  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= IQ_DEPTH);

  p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_ready && !flush) |=> int'(occ) <= int'($past(occ)));

  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(disp_n) <= WIN && int'(disp_n) <= int'(occ));

  for (genvar i = 0; i + 1 < WIN; i++) begin : g_pre
    p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid[i+1] |-> dsp_valid[i]);
  end

  p_fp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n <= FP_LIM && fp_n <= int'(fp_slots));

  p_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_n <= VEC_LIM && vec_n <= int'(vec_slots));

  p_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_n <= GEN_LIM && gen_n <= int'(gen_slots));

  p_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dsp_valid) <= int'(cq_free));

  p_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occ) == int'($past(occ)) - int'($past(disp_n))
                           + ($past(fe_ready) ? int'($past(fe_cnt)) : 0));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> dsp_valid == '0);

  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

  p_credit_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(disp_n) == $countones(dsp_valid));

  initial p_fetch_w_r1: assert (FETCH_W <= IQ_DEPTH);

endmodule

bind iq_dispatch dsp_chk #(
  .IQ_DEPTH (IQ_DEPTH),
  .WIN      (WIN),
  .FETCH_W  (FETCH_W),
  .FP_LIM   (FP_LIM),
  .VEC_LIM  (VEC_LIM),
  .GEN_LIM  (GEN_LIM),
  .CQ_W     (CQ_W),
  .SLOT_W   (SLOT_W),
  .FC_W     (FC_W),
  .CNT_W    (CNT_W),
  .NGO_W    (NGO_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .fe_cnt    (fe_cnt),
  .fe_ready  (fe_ready),
  .fp_slots  (fp_slots),
  .vec_slots (vec_slots),
  .gen_slots (gen_slots),
  .cq_free   (cq_free),
  .dsp_valid (dsp_valid),
  .dsp_cls   (dsp_cls),
  .occ       (occ),
  .disp_n    (disp_n)
);

// File: tb/sim_iq_dispatch.sv
`timescale 1ns/1ps
module sim_iq_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [1:0]  fe_cnt = '0;
  logic [5:0]  fe_cls = '0;
  logic [95:0] fe_data = '0;
  logic        fe_ready;
  logic [1:0]  fp_slots = 2'd3, vec_slots = 2'd3, gen_slots = 2'd3;
  logic [4:0]  cq_free = 5'd16;
  logic [2:0]  dsp_valid;
  logic [5:0]  dsp_cls;
  logic [95:0] dsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iq_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fe_cnt(fe_cnt), .fe_cls(fe_cls), .fe_data(fe_data), .fe_ready(fe_ready),
    .fp_slots(fp_slots), .vec_slots(vec_slots), .gen_slots(gen_slots),
    .cq_free(cq_free),
    .dsp_valid(dsp_valid), .dsp_cls(dsp_cls), .dsp_data(dsp_data)
  );

  // entry: {c0,c1,c2, fp,vec,gen slots, cq_free, expected count}
  // tags: 0 none, 1 general, 2 float, 3 vector
  localparam logic [18:0] TBL [12] = '{
    {2'd1,2'd1,2'd1, 2'd3,2'd3,2'd3, 5'd16, 2'd3},  // R4 three general
    {2'd2,2'd2,2'd1, 2'd3,2'd3,2'd3, 5'd16, 2'd1},  // R4 float limit one
    {2'd3,2'd3,2'd3, 2'd3,2'd3,2'd3, 5'd16, 2'd2},  // R4 vector limit two
    {2'd3,2'd3,2'd1, 2'd3,2'd3,2'd3, 5'd16, 2'd3},  // R4 mixed fits
    {2'd1,2'd1,2'd1, 2'd3,2'd3,2'd1, 5'd16, 2'd1},  // R4 general room one
    {2'd1,2'd2,2'd1, 2'd0,2'd3,2'd3, 5'd16, 2'd1},  // R3 float full stops younger
    {2'd2,2'd1,2'd1, 2'd3,2'd3,2'd3, 5'd2,  2'd2},  // R5 two credits
    {2'd0,2'd0,2'd0, 2'd0,2'd0,2'd0, 5'd16, 2'd3},  // R6 no queue needed
    {2'd0,2'd1,2'd0, 2'd3,2'd3,2'd3, 5'd0,  2'd0},  // R5 no credit at all
    {2'd2,2'd3,2'd1, 2'd3,2'd3,2'd3, 5'd16, 2'd3},  // R4 one of each
    {2'd1,2'd3,2'd3, 2'd3,2'd1,2'd3, 5'd16, 2'd2},  // R4 vector room one
    {2'd2,2'd1,2'd2, 2'd3,2'd3,2'd3, 5'd16, 2'd2}   // R3 second float blocks
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lane(input int k);
    return int'(dsp_data[k*32 +: 32]);
  endfunction

  task automatic clear_q();
    @(negedge clk);
    flush = 1'b1; fe_cnt = '0; cq_free = '0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 dsp_valid", int'(dsp_valid), 0);
    check("R9 fe_ready", int'(fe_ready), 1);

    // table walk
    for (int e = 0; e < 12; e++) begin
      clear_q();
      fe_cnt  = 2'd3;
      fe_cls  = {TBL[e][14:13], TBL[e][16:15], TBL[e][18:17]};
      fe_data = {32'hA000 + 32'(e*16) + 32'd2, 32'hA000 + 32'(e*16) + 32'd1, 32'hA000 + 32'(e*16)};
      @(negedge clk);
      fe_cnt    = '0;
      fp_slots  = TBL[e][12:11];
      vec_slots = TBL[e][10:9];
      gen_slots = TBL[e][8:7];
      cq_free   = TBL[e][6:2];
      #1;
      check($sformatf("R4/R5 table %0d valid", e), int'(dsp_valid), (1 << TBL[e][1:0]) - 1);
      for (int k = 0; k < 3; k++)
        if (k < int'(TBL[e][1:0]))
          check($sformatf("R2 table %0d lane %0d", e, k), lane(k), 'hA000 + e*16 + k);
      fp_slots = 2'd3; vec_slots = 2'd3; gen_slots = 2'd3;
    end

    // R1 fill to twelve, drop a group offered while full
    clear_q();
    for (int c = 0; c < 4; c++) begin
      fe_cnt = 2'd3; fe_cls = 6'b010101;
      fe_data = {32'(3*c+2), 32'(3*c+1), 32'(3*c)};
      @(negedge clk);
      #1;
      check($sformatf("R1 fe_ready after group %0d", c), int'(fe_ready), (c < 3) ? 1 : 0);
    end
    fe_data = {32'h99, 32'h99, 32'h99};
    @(negedge clk);
    fe_cnt = '0; cq_free = 5'd3;
    for (int c = 0; c < 4; c++) begin
      #1;
      check($sformatf("R7 drain %0d valid", c), int'(dsp_valid), 7);
      for (int k = 0; k < 3; k++)
        check($sformatf("R7 drain %0d lane %0d", c, k), lane(k), 3*c + k);
      @(negedge clk);
    end
    #1;
    check("R1 dropped group absent", int'(dsp_valid), 0);

    // R7 append in the same cycle as dispatch
    clear_q();
    fe_cnt = 2'd2; fe_cls = 6'b010101;
    fe_data = {32'h0, 32'h11, 32'h10};
    @(negedge clk);
    fe_data = {32'h0, 32'h13, 32'h12};
    cq_free = 5'd1;
    #1;
    check("R5 single credit", int'(dsp_valid), 1);
    check("R7 head lane", lane(0), 'h10);
    @(negedge clk);
    fe_cnt = '0; cq_free = 5'd3;
    #1;
    check("R7 merged valid", int'(dsp_valid), 7);
    check("R7 merged lane0", lane(0), 'h11);
    check("R7 merged lane1", lane(1), 'h12);
    check("R7 merged lane2", lane(2), 'h13);

    // R2 fourth entry waits
    clear_q();
    fe_cnt = 2'd3; fe_cls = 6'b010101;
    fe_data = {32'h22, 32'h21, 32'h20};
    @(negedge clk);
    fe_cnt = 2'd1; fe_data = {32'h0, 32'h0, 32'h23};
    @(negedge clk);
    fe_cnt = '0; cq_free = 5'd16;
    #1;
    check("R2 window of three", int'(dsp_valid), 7);
    @(negedge clk);
    #1;
    check("R2 fourth next cycle", int'(dsp_valid), 1);
    check("R2 fourth data", lane(0), 'h23);

    // R8 flush
    clear_q();
    fe_cnt = 2'd3; fe_cls = 6'b010101;
    fe_data = {32'h32, 32'h31, 32'h30};
    @(negedge clk);
    flush = 1'b1; cq_free = 5'd16;
    #1;
    check("R8 no dispatch in flush", int'(dsp_valid), 0);
    @(negedge clk);
    flush = 1'b0; fe_cnt = '0;
    #1;
    check("R8 empty after flush", int'(dsp_valid), 0);
    check("R8 ready after flush", int'(fe_ready), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule